// File: doc/BRIEF.md
# Serial PCM Sample Receiver

This block takes 8-bit PCM samples from a three-wire serial link made of a bit clock, a frame sync and a data line. It brings all three wires into the system clock domain and detects the edges of the bit clock there. A rising edge on the frame sync arms the receiver. The receiver then takes one data bit at each falling edge of the bit clock, most significant bit first. When the eighth bit arrives, the assembled byte is written to a parallel holding output and a valid strobe is raised for one system clock.

The block also watches the bit clock for activity. If the bit clock stays at one level for a set number of system clocks, whether high or low, the block raises a power-save flag. While the flag is set, any partly received byte is dropped. The first edge of the bit clock clears the flag again. After that, reception resumes only at the next frame sync. Because the block oversamples the link, it does not depend on one particular bit rate. Any bit clock whose high and low phases each last at least three system clocks will work.

Top module: `pcm_rx`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, `sample_o` becomes 0 and `sample_vld_o` and `pwr_save_o` become 0.
- R2: After a rising edge of `frame_sync_i`, the bit present on `ser_data_i` at each of the next eight falling edges of `bit_clk_i` is taken in arrival order. The first bit becomes bit 7 of the sample and the eighth bit becomes bit 0.
- R3: When the eighth bit is taken, `sample_o` is loaded and `sample_vld_o` is high for exactly one `clk` cycle. At all other times `sample_o` holds its value.
- R4: Falling edges of `bit_clk_i` after the eighth bit and before the next rising edge of `frame_sync_i` change neither `sample_o` nor the number of strobes.
- R5: A rising edge of `frame_sync_i` that arrives before the eighth bit drops the partial byte, so no strobe is given for it, and restarts the count.
- R6: Reception works for any `bit_clk_i` whose high and low phases each last at least 3 `clk` cycles and are shorter than `STOP_CYCLES`.
- R7: `pwr_save_o` rises after `bit_clk_i` has held the same level, high or low, for `STOP_CYCLES` to `STOP_CYCLES`+4 `clk` cycles.
- R8: `pwr_save_o` falls within 4 `clk` cycles of the first transition of `bit_clk_i`.
- R9: While `pwr_save_o` is high, no strobe is given and any partial byte is cleared, so bits that follow a resumed clock without a new frame sync give no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_clk_i | input | 1 | Serial bit clock, asynchronous to `clk` |
| frame_sync_i | input | 1 | Frame sync; a rising edge marks the MSB |
| ser_data_i | input | 1 | Serial PCM data |
| sample_o | output | 8 | Last complete received sample |
| sample_vld_o | output | 1 | One-cycle strobe when `sample_o` is loaded |
| pwr_save_o | output | 1 | High while the bit clock is stopped |

## Verification
A wrong bit count or a wrong arming state shows up at the ports within one frame. It appears as a missing strobe, an extra strobe or a shifted byte on `sample_o` about three system clocks after the eighth falling edge. A stuck stop counter shows in `pwr_save_o` within `STOP_CYCLES` plus a few cycles. A failure to clear the partial byte on power save shows as a spurious strobe in the first few bit clocks after the clock resumes without a new sync.

// File: rtl/pcm_rx_pkg.sv
// Shared definitions for the serial PCM receiver.
// Assumes: one sample width for the whole block.
package pcm_rx_pkg;
    localparam int SAMPLE_W = 8;

    // Per-cycle link events seen in the system clock domain.
    typedef struct packed {
        logic bclk_fall;   // falling edge of the bit clock
        logic bclk_any;    // any transition of the bit clock
        logic sync_rise;   // rising edge of the frame sync
        logic data;        // data bit aligned with the bit clock
    } link_evt_t;
endpackage

// File: rtl/pcm_rx_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes: the bits are independent, and each one holds a level for longer
// than STAGES system clocks.
module pcm_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage samples the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage resamples the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcm_rx_edge.sv
// Turns synchronized link levels into per-cycle edge events.
// Assumes: the inputs are already in the clk domain.
module pcm_rx_edge
    import pcm_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bclk_s,
    input  logic      sync_s,
    input  logic      data_s,
    output link_evt_t evt_o
);
    logic bclk_q;
    logic sync_q;

    // Hold the previous level of the bit clock and the frame sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            bclk_q <= bclk_s;
            sync_q <= sync_s;
        end
    end

    // Compare the current and previous levels to form the events.
    always_comb begin
        evt_o.bclk_fall = bclk_q & ~bclk_s;
        evt_o.bclk_any  = bclk_q ^ bclk_s;
        evt_o.sync_rise = sync_s & ~sync_q;
        evt_o.data      = data_s;
    end
endmodule

// File: rtl/pcm_rx_clkmon.sv
// Bit clock activity monitor in the system clock domain.
// Counts clk cycles without a bit clock transition. It raises the stop flag
// at STOP_CYCLES and drops it on the next transition.
// Assumes: STOP_CYCLES is longer than any bit clock phase in use.
module pcm_rx_clkmon #(
    parameter int STOP_CYCLES = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_any_i,
    output logic stop_o,      // registered power-save flag
    output logic halted_o     // flag, already cleared by a transition this cycle
);
    localparam int CNT_W = $clog2(STOP_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STOP_CYCLES);

    logic [CNT_W-1:0] idle_cnt;

    // Idle counter saturates at LIMIT; any transition restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            stop_o   <= 1'b0;
        end else if (bclk_any_i) begin
            idle_cnt <= '0;
            stop_o   <= 1'b0;
        end else if (idle_cnt == LIMIT) begin
            stop_o   <= 1'b1;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Lets a transition in this cycle release the receiver at once.
    assign halted_o = stop_o & ~bclk_any_i;
endmodule

// File: rtl/pcm_rx_deser.sv
// Sync-framed deserializer. A frame sync rising edge arms it. It shifts one
// bit per bit clock falling edge, MSB first, and loads the output on the
// last bit with a one-cycle strobe.
// Assumes: a falling edge in the same cycle as the sync edge is the MSB.
module pcm_rx_deser
    import pcm_rx_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  link_evt_t    evt_i,
    input  logic         halted_i,
    output logic [W-1:0] sample_o,
    output logic         vld_o
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-2:0]     shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic             armed;

    // Framing, shifting and output load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            armed    <= 1'b0;
            sample_o <= '0;
            vld_o    <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            if (halted_i) begin
                shreg   <= '0;
                bit_cnt <= '0;
                armed   <= 1'b0;
            end else if (evt_i.sync_rise) begin
                armed <= 1'b1;
                if (evt_i.bclk_fall) begin
                    shreg   <= {{(W-2){1'b0}}, evt_i.data};
                    bit_cnt <= CNT_W'(1);
                end else begin
                    shreg   <= '0;
                    bit_cnt <= '0;
                end
            end else if (armed && evt_i.bclk_fall) begin
                if (bit_cnt == LAST) begin
                    sample_o <= {shreg, evt_i.data};
                    vld_o    <= 1'b1;
                    armed    <= 1'b0;
                    bit_cnt  <= '0;
                end else begin
                    shreg   <= {shreg[W-3:0], evt_i.data};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_rx.sv
// Serial PCM receiver top. It synchronizes the link, detects edges, frames
// and deserializes samples, and flags a stopped bit clock.
// Assumes: clk is much faster than the bit clock (each phase >= 3 clk).
module pcm_rx
    import pcm_rx_pkg::*;
#(
    parameter int W           = SAMPLE_W,
    parameter int SYNC_STAGES = 2,
    parameter int STOP_CYCLES = 1600
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_clk_i,
    input  logic         frame_sync_i,
    input  logic         ser_data_i,
    output logic [W-1:0] sample_o,
    output logic         sample_vld_o,
    output logic         pwr_save_o
);
    logic [2:0] raw_lvl;
    logic [2:0] syn_lvl;
    link_evt_t  evt;
    logic       halted;

    assign raw_lvl = {bit_clk_i, frame_sync_i, ser_data_i};

    pcm_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_lvl),
        .q_o   (syn_lvl)
    );

    pcm_rx_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_s (syn_lvl[2]),
        .sync_s (syn_lvl[1]),
        .data_s (syn_lvl[0]),
        .evt_o  (evt)
    );

    pcm_rx_clkmon #(.STOP_CYCLES(STOP_CYCLES)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_any_i (evt.bclk_any),
        .stop_o     (pwr_save_o),
        .halted_o   (halted)
    );

    pcm_rx_deser #(.W(W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .halted_i (halted),
        .sample_o (sample_o),
        .vld_o    (sample_vld_o)
    );
endmodule

// File: rtl/pcm_rx_chk.sv
// Port-level properties for pcm_rx, bound into every instance.
module pcm_rx_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bit_clk_i,
    input logic [W-1:0] sample_o,
    input logic         sample_vld_o,
    input logic         pwr_save_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sample_o == '0 && !sample_vld_o && !pwr_save_o));

    // R3
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |=> !sample_vld_o);

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld_o |-> $stable(sample_o));

    // R9
    no_vld_in_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |-> !pwr_save_o);

    // R7
    save_on_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_save_o) |-> $stable(bit_clk_i));
endmodule

bind pcm_rx pcm_rx_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_clk_i    (bit_clk_i),
    .sample_o     (sample_o),
    .sample_vld_o (sample_vld_o),
    .pwr_save_o   (pwr_save_o)
);

// File: tb/tb_pcm_rx.sv
module tb_pcm_rx;
    localparam int STOP = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0;
    logic       fsync = 1'b0;
    logic       sdat = 1'b0;
    logic [7:0] smp;
    logic       vld;
    logic       psave;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic [7:0] last_smp = 8'h00;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    pcm_rx #(.STOP_CYCLES(STOP)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_clk_i    (bclk),
        .frame_sync_i (fsync),
        .ser_data_i   (sdat),
        .sample_o     (smp),
        .sample_vld_o (vld),
        .pwr_save_o   (psave)
    );

    // Count strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && vld) begin
            vcount   <= vcount + 1;
            last_smp <= smp;
        end
    end

    // Vector: {half period, stimulus byte, expected sample}
    localparam logic [23:0] VECS [6] = '{
        24'h04_A5_A5, 24'h06_3C_3C, 24'h0C_81_81,
        24'h05_FF_FF, 24'h08_00_00, 24'h07_6E_6E
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends nbits from the MSB of b, optionally with a sync on the first bit.
    task automatic send(input logic [7:0] b, input int nbits, input bit with_sync, input int half);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            bclk  = 1'b1;
            sdat  = b[7-i];
            fsync = with_sync && (i == 0);
            idle(half);
            bclk = 1'b0;
            idle(half - 1);
        end
        @(negedge clk);
        fsync = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int v0;
        logic [7:0] keep;
        idle(4);
        // R1: reset state
        check(smp == 8'h00, "R1 sample", smp, 0);
        check(vld == 1'b0, "R1 strobe", vld, 0);
        check(psave == 1'b0, "R1 psave", psave, 0);
        rst_n = 1'b1;
        idle(2);

        // R2 R3 R6: table of frames at several bit rates
        for (int k = 0; k < 6; k++) begin
            v0 = vcount;
            send(VECS[k][15:8], 8, 1'b1, int'(VECS[k][23:16]));
            idle(6);
            check(last_smp == VECS[k][7:0], "R2 R6 sample", last_smp, VECS[k][7:0]);
            check(vcount == v0 + 1, "R3 one strobe", vcount - v0, 1);
            check(psave == 1'b0, "R7 no save while running", psave, 0);
        end

        // R4: extra bits after the eighth are ignored
        v0 = vcount;
        send(8'h5A, 8, 1'b1, 5);
        send(8'hFF, 6, 1'b0, 5);
        idle(6);
        check(last_smp == 8'h5A && smp == 8'h5A, "R4 sample kept", smp, 8'h5A);
        check(vcount == v0 + 1, "R4 no extra strobe", vcount - v0, 1);

        // R5: sync mid-byte aborts the partial byte
        v0 = vcount;
        send(8'hF0, 4, 1'b1, 5);
        send(8'h96, 8, 1'b1, 5);
        idle(6);
        check(smp == 8'h96, "R5 restart sample", smp, 8'h96);
        check(vcount == v0 + 1, "R5 no partial strobe", vcount - v0, 1);

        // R7: static low clock raises power save
        idle(STOP + 10);
        check(psave == 1'b1, "R7 static low", psave, 1);
        // R8: first transition drops it
        @(negedge clk);
        bclk = 1'b1;
        idle(5);
        check(psave == 1'b0, "R8 resume", psave, 0);
        // R7: static high clock raises power save
        idle(STOP + 10);
        check(psave == 1'b1, "R7 static high", psave, 1);
        bclk = 1'b0;
        idle(5);
        check(psave == 1'b0, "R8 resume low", psave, 0);

        // R9: partial byte cleared by power save
        v0 = vcount;
        keep = smp;
        send(8'hC3, 4, 1'b1, 5);
        idle(STOP + 10);
        check(psave == 1'b1, "R9 save during byte", psave, 1);
        send(8'h3C, 6, 1'b0, 5);
        idle(6);
        check(vcount == v0, "R9 no strobe after resume", vcount - v0, 0);
        check(smp == keep, "R9 sample kept", smp, keep);
        send(8'h42, 8, 1'b1, 5);
        idle(6);
        check(smp == 8'h42 && vcount == v0 + 1, "R9 clean restart", smp, 8'h42);

        // R1: reset mid-run clears outputs
        send(8'hE7, 3, 1'b1, 5);
        rst_n = 1'b0;
        idle(3);
        check(smp == 8'h00 && vld == 1'b0 && psave == 1'b0, "R1 reset again", smp, 0);
        rst_n = 1'b1;
        idle(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule